// File: doc/BRIEF.md
# Video standard supervisor

This block keeps the output format of an on-screen-display controller in step with the analog video standard arriving at its input. A host issues a service pulse, for example once per display refresh. On each pulse the block reads the controller's mode register back through a simple request/acknowledge register port. If the value read differs from the value it last wrote, it rebuilds the mode at once and fires a one-cycle reinitialisation strobe. The other logic on the chip uses that strobe to redraw the screen.

In automatic configuration the block also polls the controller's status byte, but only after the poll interval has run out. It compares the detected input standard with the current output standard. Any mismatch must outlast a debounce window before the output is switched. A loss-of-signal indication disarms the debounce window. The NTSC rule is tolerant: a status byte that shows neither loss of signal nor PAL counts as NTSC input. When the block chooses a standard during initialisation in automatic configuration, it falls back to NTSC if no valid standard is present. In forced PAL or forced NTSC configuration, the status byte is never read.

The control is a single state machine with the states IDLE, RD_MODE, COMPARE, RD_STAT, JUDGE, PICK, RD_INIT, DECIDE, WR_MODE and STROBE. The transitions are as follows:
- IDLE goes to PICK on a service pulse before the first initialisation, and to RD_MODE after it.
- RD_MODE goes to COMPARE on acknowledge.
- From COMPARE the block goes to PICK on a readback mismatch (stall). Otherwise it goes to RD_STAT when the configuration is automatic and a poll is due, and back to IDLE in every other case.
- RD_STAT goes to JUDGE on acknowledge.
- JUDGE goes to PICK when the debounce window has expired on a valid mismatch, and to IDLE otherwise.
- PICK goes to RD_INIT in automatic configuration and to WR_MODE in forced configuration.
- RD_INIT goes to DECIDE on acknowledge, and DECIDE goes to WR_MODE.
- WR_MODE goes to STROBE on acknowledge, and STROBE returns to IDLE.

Top module: `video_std_supervisor`

## Requirements
- R1: After reset `reg_req` and `reinit` are low and `fmt_pal` is 0 (NTSC).
- R2: The first service pulse after reset performs an initialisation without reading the mode register back: a mode write, then one `reinit` pulse.
- R3: Every write goes to `MODE_ADDR` with data 8'h48 for PAL or 8'h08 for NTSC (bit 6 = PAL, bit 3 = display enable, all other bits 0). `fmt_pal` takes bit 6 of the written value in the cycle after the write acknowledge.
- R4: `cfg_mode` 2'b01 forces PAL and 2'b10 forces NTSC; 2'b00 and 2'b11 mean automatic. In forced configuration the status register at `STAT_ADDR` is never read.
- R5: An initialisation in automatic configuration reads the status byte, in which bit 0 = PAL seen, bit 1 = NTSC seen and bit 2 = loss of signal. It picks NTSC when bit 1 is set and bit 2 is clear. Otherwise it picks PAL when bit 0 is set and bit 2 is clear. In every other case it falls back to NTSC.
- R6: Once initialised, every service pass reads `MODE_ADDR`. A value other than the last one written starts an initialisation in the same pass.
- R7: In automatic configuration, a pass reads the status byte only when more than `POLL_MS` ticks have elapsed since the previous poll (or since reset).
- R8: A polled status byte with loss of signal clear is a mismatch when bit 0 is set while the output is NTSC, or when bit 0 is clear while the output is PAL, whatever bit 1 shows.
- R9: The first mismatch only arms the debounce window and stamps the tick count. A later mismatching poll starts an initialisation only when more than `DEBOUNCE_MS` ticks have elapsed since that stamp.
- R10: A poll that shows loss of signal disarms the debounce window, so the next mismatch arms it again from its own time.
- R11: A poll without mismatch leaves an armed window and its stamp unchanged.
- R12: `reinit` is high for exactly one cycle, directly after the mode write is acknowledged, and the debounce window is disarmed afterwards.
- R13: `reg_req`, `reg_wr`, `reg_addr` and `reg_wdata` are held steady until `reg_ack`. A service pulse that arrives while a pass is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms | input | 1 | One-cycle pulse per millisecond |
| svc_req | input | 1 | Service pulse that starts a supervision pass |
| cfg_mode | input | 2 | 01 forced PAL, 10 forced NTSC, 00/11 automatic |
| reg_req | output | 1 | Register access request, held until acknowledge |
| reg_wr | output | 1 | 1 = write, 0 = read |
| reg_addr | output | ADDR_W | Register address |
| reg_wdata | output | 8 | Write data |
| reg_ack | input | 1 | One-cycle access acknowledge |
| reg_rdata | input | 8 | Read data, valid with `reg_ack` |
| reinit | output | 1 | One-cycle reinitialisation strobe |
| fmt_pal | output | 1 | Current output standard, 1 = PAL |

## Verification
A wrong internal state shows up at the ports in one of three ways: an unexpected mode write, a missing `reinit` pulse, or a status read at the wrong time. Each appears within one service pass of the poll or readback that should have caused it. A lost debounce stamp shows up as an early or late switch, one poll interval away from the expected one. A poll timer that is wrong shows up as a status read one tick too early or too late. The tests therefore step the tick count to the exact boundaries (elapsed equal to the limit, and one more). They count reads, writes and strobe cycles at the register port.

// File: rtl/vsd_pkg.sv
package vsd_pkg;
    localparam int DATA_W       = 8;
    localparam int MODE_PAL_BIT = 6;
    localparam int MODE_EN_BIT  = 3;
    localparam int ST_PAL_BIT   = 0;
    localparam int ST_NTSC_BIT  = 1;
    localparam int ST_LOS_BIT   = 2;
    localparam int ST_USED_W    = 3;

    localparam logic [1:0] CFG_FORCE_PAL  = 2'b01;
    localparam logic [1:0] CFG_FORCE_NTSC = 2'b10;

    typedef enum logic [3:0] {
        ST_IDLE    = 4'd0,
        ST_RD_MODE = 4'd1,
        ST_COMPARE = 4'd2,
        ST_RD_STAT = 4'd3,
        ST_JUDGE   = 4'd4,
        ST_PICK    = 4'd5,
        ST_RD_INIT = 4'd6,
        ST_DECIDE  = 4'd7,
        ST_WR_MODE = 4'd8,
        ST_STROBE  = 4'd9
    } sup_state_t;

    function automatic logic [DATA_W-1:0] mode_byte(input logic pal);
        logic [DATA_W-1:0] v;
        v = '0;
        v[MODE_EN_BIT]  = 1'b1;
        v[MODE_PAL_BIT] = pal;
        return v;
    endfunction

    function automatic logic cfg_is_auto(input logic [1:0] cfg);
        return (cfg != CFG_FORCE_PAL) && (cfg != CFG_FORCE_NTSC);
    endfunction
endpackage

// File: rtl/vsd_ms_timer.sv
module vsd_ms_timer #(
    parameter int TIME_W  = 16,
    parameter int POLL_MS = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_ms,
    input  logic              mark_poll,
    output logic [TIME_W-1:0] now,
    output logic              poll_due
);
    localparam logic [TIME_W-1:0] POLL_LIM = TIME_W'(POLL_MS);

    logic [TIME_W-1:0] count_q;
    logic [TIME_W-1:0] last_q;
    logic [TIME_W-1:0] gap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (tick_ms) begin
            count_q <= count_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q <= '0;
        end else if (mark_poll) begin
            last_q <= count_q;
        end
    end

    assign now      = count_q;
    assign gap      = count_q - last_q;
    assign poll_due = (gap > POLL_LIM);
endmodule

// File: rtl/vsd_status_decode.sv
module vsd_status_decode
    import vsd_pkg::*;
(
    input  logic [ST_USED_W-1:0] stat,
    input  logic                 out_pal,
    output logic                 los,
    output logic                 mismatch,
    output logic                 pick_pal
);
    logic pal_valid;
    logic ntsc_strict;
    logic ntsc_loose;

    always_comb begin
        los         = stat[ST_LOS_BIT];
        pal_valid   = !los && stat[ST_PAL_BIT];
        ntsc_strict = !los && stat[ST_NTSC_BIT];
        // tolerant rule: no loss and no PAL flag counts as NTSC input
        ntsc_loose  = !los && !stat[ST_PAL_BIT];
        mismatch    = (pal_valid && !out_pal) || (ntsc_loose && out_pal);
        // initial choice: strict NTSC first, then PAL, otherwise NTSC fallback
        pick_pal    = !ntsc_strict && pal_valid;
    end
endmodule

// File: rtl/vsd_debounce.sv
module vsd_debounce #(
    parameter int TIME_W      = 16,
    parameter int DEBOUNCE_MS = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIME_W-1:0] now,
    input  logic              observe,
    input  logic              mismatch,
    input  logic              los_seen,
    input  logic              clear,
    output logic              armed,
    output logic              expired
);
    localparam logic [TIME_W-1:0] DEB_LIM = TIME_W'(DEBOUNCE_MS);

    logic [TIME_W-1:0] stamp_q;
    logic              armed_q;
    logic [TIME_W-1:0] held;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            stamp_q <= '0;
        end else if (clear || los_seen) begin
            armed_q <= 1'b0;
        end else if (observe && mismatch && !armed_q) begin
            armed_q <= 1'b1;
            stamp_q <= now;
        end
    end

    assign held    = now - stamp_q;
    assign armed   = armed_q;
    assign expired = armed_q && (held > DEB_LIM);
endmodule

// File: rtl/video_std_supervisor.sv
module video_std_supervisor
    import vsd_pkg::*;
#(
    parameter int                TIME_W      = 16,
    parameter int                POLL_MS     = 1000,
    parameter int                DEBOUNCE_MS = 100,
    parameter int                ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] MODE_ADDR   = 8'h00,
    parameter logic [ADDR_W-1:0] STAT_ADDR   = 8'hA0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_ms,
    input  logic              svc_req,
    input  logic [1:0]        cfg_mode,
    output logic              reg_req,
    output logic              reg_wr,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_ack,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic              reinit,
    output logic              fmt_pal
);
    sup_state_t state_q, state_d;

    logic [DATA_W-1:0] rd_q;
    logic              fmt_pal_q;
    logic              target_q;
    logic              init_done_q;

    logic [TIME_W-1:0] now;
    logic              poll_due;
    logic              los;
    logic              mismatch;
    logic              pick_pal;
    logic              deb_armed;
    logic              deb_expired;
    logic              in_judge;
    logic              in_strobe;
    logic              auto_cfg;

    assign in_judge  = (state_q == ST_JUDGE);
    assign in_strobe = (state_q == ST_STROBE);
    assign auto_cfg  = cfg_is_auto(cfg_mode);

    vsd_ms_timer #(
        .TIME_W  (TIME_W),
        .POLL_MS (POLL_MS)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_ms   (tick_ms),
        .mark_poll (in_judge),
        .now       (now),
        .poll_due  (poll_due)
    );

    vsd_status_decode u_decode (
        .stat     (rd_q[ST_USED_W-1:0]),
        .out_pal  (fmt_pal_q),
        .los      (los),
        .mismatch (mismatch),
        .pick_pal (pick_pal)
    );

    vsd_debounce #(
        .TIME_W      (TIME_W),
        .DEBOUNCE_MS (DEBOUNCE_MS)
    ) u_debounce (
        .clk      (clk),
        .rst_n    (rst_n),
        .now      (now),
        .observe  (in_judge),
        .mismatch (mismatch),
        .los_seen (in_judge && los),
        .clear    (in_strobe),
        .armed    (deb_armed),
        .expired  (deb_expired)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (svc_req) begin
                    state_d = init_done_q ? ST_RD_MODE : ST_PICK;
                end
            end
            ST_RD_MODE: begin
                if (reg_ack) state_d = ST_COMPARE;
            end
            ST_COMPARE: begin
                if (rd_q != mode_byte(fmt_pal_q)) begin
                    state_d = ST_PICK;
                end else if (auto_cfg && poll_due) begin
                    state_d = ST_RD_STAT;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_RD_STAT: begin
                if (reg_ack) state_d = ST_JUDGE;
            end
            ST_JUDGE: begin
                if (!los && mismatch && deb_expired) begin
                    state_d = ST_PICK;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_PICK: begin
                state_d = auto_cfg ? ST_RD_INIT : ST_WR_MODE;
            end
            ST_RD_INIT: begin
                if (reg_ack) state_d = ST_DECIDE;
            end
            ST_DECIDE: begin
                state_d = ST_WR_MODE;
            end
            ST_WR_MODE: begin
                if (reg_ack) state_d = ST_STROBE;
            end
            ST_STROBE: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q        <= '0;
            fmt_pal_q   <= 1'b0;
            target_q    <= 1'b0;
            init_done_q <= 1'b0;
        end else begin
            if (reg_ack && (state_q == ST_RD_MODE || state_q == ST_RD_STAT ||
                            state_q == ST_RD_INIT)) begin
                rd_q <= reg_rdata;
            end
            if (state_q == ST_PICK && !auto_cfg) begin
                target_q <= (cfg_mode == CFG_FORCE_PAL);
            end
            if (state_q == ST_DECIDE) begin
                target_q <= pick_pal;
            end
            if (state_q == ST_WR_MODE && reg_ack) begin
                fmt_pal_q   <= target_q;
                init_done_q <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        reg_req   = 1'b0;
        reg_wr    = 1'b0;
        reg_addr  = MODE_ADDR;
        reg_wdata = '0;
        reinit    = 1'b0;
        unique case (state_q)
            ST_RD_MODE: begin
                reg_req = 1'b1;
            end
            ST_RD_STAT, ST_RD_INIT: begin
                reg_req  = 1'b1;
                reg_addr = STAT_ADDR;
            end
            ST_WR_MODE: begin
                reg_req   = 1'b1;
                reg_wr    = 1'b1;
                reg_wdata = mode_byte(target_q);
            end
            ST_STROBE: begin
                reinit = 1'b1;
            end
            default: begin
                reg_req = 1'b0;
            end
        endcase
    end

    assign fmt_pal = fmt_pal_q;

    logic unused_ok;
    assign unused_ok = deb_armed;
endmodule

// File: rtl/vsd_chk.sv
module vsd_chk
    import vsd_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] MODE_ADDR = 8'h00
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        cfg_mode,
    input logic              reg_req,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              reg_ack,
    input logic              reinit,
    input logic              fmt_pal
);
    // R12
    strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reinit |=> !reinit);

    // R12
    strobe_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reinit |-> $past(reg_req && reg_wr && reg_ack));

    // R3
    write_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && reg_wr) |-> (reg_addr == MODE_ADDR && reg_wdata[MODE_EN_BIT] &&
            ((reg_wdata & ~mode_byte(1'b1)) == '0)));

    // R3
    fmt_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && reg_wr && reg_ack) |=> (reinit && fmt_pal == $past(reg_wdata[MODE_PAL_BIT])));

    // R13
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && !reg_ack) |=> (reg_req && $stable(reg_wr) && $stable(reg_addr) &&
            $stable(reg_wdata)));

    // R4
    forced_no_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_is_auto(cfg_mode) && $stable(cfg_mode) && reg_req && !reg_wr) |->
            (reg_addr == MODE_ADDR));
endmodule

bind video_std_supervisor vsd_chk #(
    .ADDR_W    (ADDR_W),
    .MODE_ADDR (MODE_ADDR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_mode  (cfg_mode),
    .reg_req   (reg_req),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_ack   (reg_ack),
    .reinit    (reinit),
    .fmt_pal   (fmt_pal)
);

// File: tb/video_std_supervisor_test.sv
module video_std_supervisor_test;
    localparam int CLK_PERIOD = 10;
    localparam int POLL       = 20;
    localparam int DEB        = 30;
    localparam logic [7:0] MADDR = 8'h00;
    localparam logic [7:0] SADDR = 8'hA0;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_ms = 1'b0;
    logic       svc_req = 1'b0;
    logic [1:0] cfg_mode = 2'b00;
    logic       reg_req, reg_wr, reg_ack, reinit, fmt_pal;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;

    int n_chk = 0, n_fail = 0;
    int n_wr = 0, n_stat = 0, n_mrd = 0, n_reinit = 0;
    logic [7:0] last_wd = 8'h00;
    logic [7:0] dev_mode = 8'h00;
    logic [7:0] dev_stat = 8'h00;
    logic [1:0] dly = 2'd0;
    logic       ack_q = 1'b0;
    logic [7:0] rdata_q = 8'h00;

    always #(CLK_PERIOD/2) clk = ~clk;

    video_std_supervisor #(
        .POLL_MS(POLL), .DEBOUNCE_MS(DEB), .MODE_ADDR(MADDR), .STAT_ADDR(SADDR)
    ) uut (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .svc_req(svc_req),
        .cfg_mode(cfg_mode), .reg_req(reg_req), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_ack(reg_ack),
        .reg_rdata(reg_rdata), .reinit(reinit), .fmt_pal(fmt_pal)
    );

    assign reg_ack   = ack_q;
    assign reg_rdata = rdata_q;

    // register device model: acknowledges two cycles after a request
    always @(posedge clk) begin
        if (reg_req && !ack_q) begin
            if (dly == 2'd1) begin
                dly   <= 2'd0;
                ack_q <= 1'b1;
                if (reg_wr) begin
                    dev_mode = reg_wdata;
                    last_wd  <= reg_wdata;
                    n_wr++;
                end else if (reg_addr == MADDR) begin
                    rdata_q <= dev_mode;
                    n_mrd++;
                end else begin
                    rdata_q <= dev_stat;
                    n_stat++;
                end
            end else begin
                dly <= dly + 2'd1;
            end
        end else begin
            ack_q <= 1'b0;
        end
        if (reinit) n_reinit++;
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic service();
        @(negedge clk) svc_req = 1'b1;
        @(negedge clk) svc_req = 1'b0;
        repeat (40) @(negedge clk);
    endtask

    task automatic advance(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick_ms = 1'b1;
            @(negedge clk) tick_ms = 1'b0;
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 req", int'(reg_req), 0);
        chk("R1 reinit", int'(reinit), 0);
        chk("R1 fmt", int'(fmt_pal), 0);
    endtask

    task automatic t_first_init();
        cfg_mode = 2'b00;
        dev_stat = 8'h01;
        service();
        chk("R2 no readback", n_mrd, 0);
        chk("R2 writes", n_wr, 1);
        chk("R2 strobe cycles", n_reinit, 1);
        chk("R5 stat read", n_stat, 1);
        chk("R3 pal byte", int'(last_wd), 8'h48);
        chk("R3 fmt pal", int'(fmt_pal), 1);
    endtask

    task automatic t_stall();
        service();
        chk("R6 readback", n_mrd, 1);
        chk("R6 quiet no write", n_wr, 1);
        dev_mode = 8'h00;
        service();
        chk("R6 stall write", n_wr, 2);
        chk("R6 stall strobe", n_reinit, 2);
        chk("R6 rewritten", int'(last_wd), 8'h48);
    endtask

    task automatic t_poll();
        int s0;
        s0 = n_stat;
        advance(20);
        service();
        chk("R7 not due at limit", n_stat, s0);
        advance(1);
        service();
        chk("R7 due past limit", n_stat, s0 + 1);
        chk("R7 match no strobe", n_reinit, 2);
    endtask

    task automatic t_debounce();
        dev_stat = 8'h00;
        advance(21);
        service();
        chk("R9 arm only", n_reinit, 2);
        advance(30);
        service();
        chk("R9 equal window no switch", n_reinit, 2);
        advance(31);
        service();
        chk("R8 loose ntsc switch", n_reinit, 3);
        chk("R5 fallback ntsc", int'(last_wd), 8'h08);
        chk("R3 fmt ntsc", int'(fmt_pal), 0);
    endtask

    task automatic t_los();
        dev_stat = 8'h01;
        advance(21);
        service();
        chk("R8 pal arm", n_reinit, 3);
        dev_stat = 8'h05;
        advance(21);
        service();
        chk("R10 los no switch", n_reinit, 3);
        dev_stat = 8'h01;
        advance(21);
        service();
        chk("R10 rearm after los", n_reinit, 3);
        advance(31);
        service();
        chk("R10 switch after rearm", n_reinit, 4);
        chk("R5 pick pal", int'(last_wd), 8'h48);
    endtask

    task automatic t_hold();
        dev_stat = 8'h02;
        advance(21);
        service();
        chk("R12 window cleared", n_reinit, 4);
        dev_stat = 8'h01;
        advance(21);
        service();
        chk("R11 match no switch", n_reinit, 4);
        dev_stat = 8'h02;
        advance(21);
        service();
        chk("R11 held stamp switch", n_reinit, 5);
        chk("R11 ntsc byte", int'(last_wd), 8'h08);
    endtask

    task automatic t_forced();
        int s0;
        s0 = n_stat;
        cfg_mode = 2'b01;
        dev_mode = 8'h00;
        service();
        chk("R4 forced pal byte", int'(last_wd), 8'h48);
        chk("R4 forced pal fmt", int'(fmt_pal), 1);
        dev_stat = 8'h02;
        advance(50);
        service();
        chk("R4 no poll", n_stat, s0);
        chk("R4 no switch", n_reinit, 6);
        cfg_mode = 2'b10;
        dev_mode = 8'h00;
        service();
        chk("R4 forced ntsc byte", int'(last_wd), 8'h08);
        chk("R4 still no stat", n_stat, s0);
    endtask

    task automatic t_busy();
        int m0;
        m0 = n_mrd;
        @(negedge clk) svc_req = 1'b1;
        @(negedge clk) svc_req = 1'b0;
        @(negedge clk) svc_req = 1'b1;
        @(negedge clk) svc_req = 1'b0;
        repeat (40) @(negedge clk);
        chk("R13 busy ignored", n_mrd, m0 + 1);
    endtask

    task automatic t_init_pick();
        cfg_mode = 2'b11;
        dev_stat = 8'h03;
        dev_mode = 8'h00;
        service();
        chk("R5 ntsc priority", int'(last_wd), 8'h08);
        dev_stat = 8'h05;
        dev_mode = 8'h00;
        service();
        chk("R5 los fallback", int'(last_wd), 8'h08);
        chk("R5 fmt after fallback", int'(fmt_pal), 0);
        dev_stat = 8'h01;
        dev_mode = 8'h00;
        service();
        chk("R5 pal pick", int'(last_wd), 8'h48);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_reset();
        t_first_init();
        t_stall();
        t_poll();
        t_debounce();
        t_los();
        t_hold();
        t_forced();
        t_busy();
        t_init_pick();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got 0 expected 1");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule